// File: doc/BRIEF.md
# DRAM Bank with In-Array Row Copy

This block is a synchronous model of one small DRAM bank, extended so that a whole row can be duplicated into another row without the data ever leaving the bank. An activation, strobed by the row strobe while the bank is closed, reads the addressed row into a column latch. When the copy-select input is low during that activation, the row is also captured in a separate row buffer, together with its row number. Column reads and writes while a row is open touch only the column latch. A restore strobe writes a row back into the open row and closes the bank. At that point the copy-select input drives the restore multiplexer: low selects the column latch, high selects the row buffer.

To copy a row, first activate the source row with copy-select low and restore it normally. Then activate the destination row with copy-select high, so that the buffer keeps the source data, and restore with copy-select high. The destination then holds the source row. A copy whose destination is the row held in the buffer is refused: nothing is written and an error flag is raised.

Top module: `rowcopy_dram`

## Requirements
- R1: When the bank is closed and `ras_i` is high at a clock edge, the row at `row_addr_i` opens at that edge. `row_open_o` goes high and the column latch holds the row's contents. `col_rdata_o` always shows the latch column selected by `col_addr_i`, combinationally.
- R2: An activation with `ws_i` low also loads the row buffer and records that row as the copy source. An activation with `ws_i` high leaves the buffer and the recorded source row unchanged. Column writes never change the buffer.
- R3: While a row is open, `col_we_i` writes `col_wdata_i` into latch column `col_addr_i`. The change shows on `col_rdata_o` after the edge, and the array is not changed until a restore.
- R4: With a row open, `rw_i` high at an edge with `ws_i` low writes the column latch into the open row and closes the bank. A column write in that same cycle is included in the restored data.
- R5: With a row open, `rw_i` high at an edge with `ws_i` high writes the row buffer into the open row and closes the bank. A column write in that same cycle has no effect on the array.
- R6: If a copy restore (`rw_i` and `ws_i` high) targets the row recorded as the copy source, no row is written and the bank closes. `copy_err_o` goes high after that edge and stays high until the next activation edge, where it clears.
- R7: `ras_i` while a row is open, and `rw_i` or `col_we_i` while the bank is closed, are ignored: the bank state and the latch stay as they were.
- R8: After synchronous reset the bank is closed, `copy_err_o` is low, and the latch and buffer read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_addr_i | input | 10 | Row address for activation |
| ras_i | input | 1 | Row strobe: activates a row when the bank is closed |
| rw_i | input | 1 | Restore strobe: writes back and closes the open row |
| ws_i | input | 1 | Copy select: buffer load at activation, mux select at restore |
| col_addr_i | input | 3 | Column select for latch read and write |
| col_we_i | input | 1 | Column write strobe into the latch |
| col_wdata_i | input | 8 | Column write data |
| col_rdata_o | output | 8 | Selected latch column |
| row_open_o | output | 1 | A row is open |
| copy_err_o | output | 1 | Last copy was refused because source equals destination |

## Verification
The column write and the restore can fall in the same cycle. The bench provokes this by raising `col_we_i` together with `rw_i`, once with `ws_i` low and once with `ws_i` high. It then reopens the row and reads every column. With `ws_i` low, the written column must hold the new byte. With `ws_i` high, the whole row must equal the source row and the written byte must be absent.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
    localparam int DEF_ROW_AW = 10;
    localparam int DEF_COL_AW = 3;
    localparam int DEF_COL_W  = 8;

    typedef enum logic {
        BANK_IDLE = 1'b0,
        BANK_OPEN = 1'b1
    } bank_state_e;

    typedef struct packed {
        logic act;       // row activation this cycle
        logic buf_load;  // capture activated row into buffer
        logic restore;   // write-back this cycle
        logic sel_buf;   // restore mux picks buffer
        logic mem_we;    // array write enable
    } bank_ctl_t;
endpackage

// File: rtl/rcd_array.sv
module rcd_array #(
    parameter int ROW_AW = 10,
    parameter int ROW_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ROW_AW-1:0] rd_addr,
    output logic [ROW_W-1:0]  rd_data,
    input  logic              we,
    input  logic [ROW_AW-1:0] wr_addr,
    input  logic [ROW_W-1:0]  wr_data
);
    localparam int ROWS = 1 << ROW_AW;

    logic [ROW_W-1:0] mem [ROWS];

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_addr] <= wr_data;
        end
    end

    AST_WE_ADDR_KNOWN: assert property (@(posedge clk) disable iff (rst)
        we |-> !$isunknown(wr_addr)) else $error("write address unknown"); // R4
endmodule

// File: rtl/rcd_ctrl.sv
module rcd_ctrl
    import rcd_pkg::*;
#(
    parameter int ROW_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_i,
    input  logic              rw_i,
    input  logic              ws_i,
    input  logic [ROW_AW-1:0] row_addr_i,
    output bank_ctl_t         ctl,
    output logic [ROW_AW-1:0] open_row,
    output logic              is_open,
    output logic              err
);
    bank_state_e       state_q;
    logic [ROW_AW-1:0] open_row_q;
    logic [ROW_AW-1:0] src_row_q;
    logic              src_valid_q;
    logic              err_q;
    logic              copy_bad;

    always_comb begin
        ctl.act      = (state_q == BANK_IDLE) && ras_i;
        ctl.buf_load = ctl.act && !ws_i;
        ctl.restore  = (state_q == BANK_OPEN) && rw_i;
        ctl.sel_buf  = ws_i;
        copy_bad     = ctl.restore && ws_i && src_valid_q && (open_row_q == src_row_q);
        ctl.mem_we   = ctl.restore && !copy_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= BANK_IDLE;
            open_row_q  <= '0;
            src_row_q   <= '0;
            src_valid_q <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            if (ctl.act) begin
                state_q    <= BANK_OPEN;
                open_row_q <= row_addr_i;
                err_q      <= 1'b0;
            end else if (ctl.restore) begin
                state_q <= BANK_IDLE;
                if (copy_bad) begin
                    err_q <= 1'b1;
                end
            end
            if (ctl.buf_load) begin
                src_row_q   <= row_addr_i;
                src_valid_q <= 1'b1;
            end
        end
    end

    assign open_row = open_row_q;
    assign is_open  = (state_q == BANK_OPEN);
    assign err      = err_q;

    AST_OPEN_ON_ACT: assert property (@(posedge clk) disable iff (rst)
        (!is_open && ras_i) |=> (is_open && open_row == $past(row_addr_i))) else $error("activation"); // R1
    AST_CLOSE_ON_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (is_open && rw_i) |=> !is_open) else $error("restore close"); // R4
    AST_OPEN_IGNORES_RAS: assert property (@(posedge clk) disable iff (rst)
        (is_open && ras_i && !rw_i) |=> (is_open && $stable(open_row))) else $error("ras while open"); // R7
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (err && !ctl.act) |=> err) else $error("err dropped"); // R6
endmodule

// File: rtl/rcd_rowregs.sv
module rcd_rowregs #(
    parameter int COL_AW = 3,
    parameter int COL_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                act,
    input  logic                buf_load,
    input  logic                sel_buf,
    input  logic [ROW_W_L-1:0]  arr_rd,
    input  logic                col_we,
    input  logic [COL_AW-1:0]   col_addr,
    input  logic [COL_W-1:0]    col_wdata,
    output logic [COL_W-1:0]    col_rdata,
    output logic [ROW_W_L-1:0]  restore_data
);
    localparam int COLS    = 1 << COL_AW;
    localparam int ROW_W_L = COLS * COL_W;

    logic [ROW_W_L-1:0] latch_q;
    logic [ROW_W_L-1:0] buf_q;
    logic [ROW_W_L-1:0] merged;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign merged[c*COL_W +: COL_W] =
            (col_we && (col_addr == COL_AW'(c))) ? col_wdata : latch_q[c*COL_W +: COL_W];
    end

    assign restore_data = sel_buf ? buf_q : merged;
    assign col_rdata    = latch_q[col_addr*COL_W +: COL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            buf_q   <= '0;
        end else begin
            latch_q <= act ? arr_rd : merged;
            if (buf_load) begin
                buf_q <= arr_rd;
            end
        end
    end

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !buf_load |=> $stable(buf_q)) else $error("buffer changed"); // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!act && !col_we) |=> $stable(latch_q)) else $error("latch changed"); // R7
endmodule

// File: rtl/rowcopy_dram.sv
module rowcopy_dram
    import rcd_pkg::*;
#(
    parameter int ROW_AW = DEF_ROW_AW,
    parameter int COL_AW = DEF_COL_AW,
    parameter int COL_W  = DEF_COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ROW_AW-1:0] row_addr_i,
    input  logic              ras_i,
    input  logic              rw_i,
    input  logic              ws_i,
    input  logic [COL_AW-1:0] col_addr_i,
    input  logic              col_we_i,
    input  logic [COL_W-1:0]  col_wdata_i,
    output logic [COL_W-1:0]  col_rdata_o,
    output logic              row_open_o,
    output logic              copy_err_o
);
    localparam int ROW_W = (1 << COL_AW) * COL_W;

    bank_ctl_t         ctl;
    logic [ROW_AW-1:0] open_row;
    logic              is_open;
    logic              err;
    logic [ROW_W-1:0]  arr_rd;
    logic [ROW_W-1:0]  restore_data;

    rcd_ctrl #(.ROW_AW(ROW_AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ras_i      (ras_i),
        .rw_i       (rw_i),
        .ws_i       (ws_i),
        .row_addr_i (row_addr_i),
        .ctl        (ctl),
        .open_row   (open_row),
        .is_open    (is_open),
        .err        (err)
    );

    rcd_array #(.ROW_AW(ROW_AW), .ROW_W(ROW_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (row_addr_i),
        .rd_data (arr_rd),
        .we      (ctl.mem_we),
        .wr_addr (open_row),
        .wr_data (restore_data)
    );

    rcd_rowregs #(.COL_AW(COL_AW), .COL_W(COL_W)) u_rows (
        .clk          (clk),
        .rst          (rst),
        .act          (ctl.act),
        .buf_load     (ctl.buf_load),
        .sel_buf      (ctl.sel_buf),
        .arr_rd       (arr_rd),
        .col_we       (col_we_i && is_open),
        .col_addr     (col_addr_i),
        .col_wdata    (col_wdata_i),
        .col_rdata    (col_rdata_o),
        .restore_data (restore_data)
    );

    assign row_open_o = is_open;
    assign copy_err_o = err;

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !row_open_o |-> !ctl.mem_we) else $error("write while closed"); // R7
    AST_ERR_MEANS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(copy_err_o) |-> !$past(ctl.mem_we)) else $error("refused copy wrote"); // R6
endmodule

// File: tb/rowcopy_dram_test.sv
`timescale 1ns/1ps
module rowcopy_dram_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] row_addr_i = '0;
    logic       ras_i = 1'b0, rw_i = 1'b0, ws_i = 1'b0, col_we_i = 1'b0;
    logic [2:0] col_addr_i = '0;
    logic [7:0] col_wdata_i = '0;
    logic [7:0] col_rdata_o;
    logic       row_open_o, copy_err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rowcopy_dram uut (
        .clk(clk), .rst(rst), .row_addr_i(row_addr_i), .ras_i(ras_i), .rw_i(rw_i),
        .ws_i(ws_i), .col_addr_i(col_addr_i), .col_we_i(col_we_i),
        .col_wdata_i(col_wdata_i), .col_rdata_o(col_rdata_o),
        .row_open_o(row_open_o), .copy_err_o(copy_err_o)
    );

    // row, column, byte: written then read back
    localparam logic [20:0] VEC [8] = '{
        {10'd100, 3'd0, 8'h3C}, {10'd101, 3'd7, 8'hA5}, {10'd1023, 3'd3, 8'hFF},
        {10'd0,   3'd5, 8'h00}, {10'd512, 3'd1, 8'h5A}, {10'd777, 3'd6, 8'hC3},
        {10'd100, 3'd4, 8'h81}, {10'd300, 3'd2, 8'h7E}
    };

    function automatic logic [7:0] pat(input int r, input int c);
        return 8'((r * 7 + c * 29 + 3) & 255);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic activate(input int r, input logic ws);
        row_addr_i = 10'(r); ras_i = 1'b1; ws_i = ws;
        tick();
        ras_i = 1'b0; ws_i = 1'b0;
    endtask

    task automatic colwr(input int c, input logic [7:0] d);
        col_addr_i = 3'(c); col_wdata_i = d; col_we_i = 1'b1;
        tick();
        col_we_i = 1'b0;
    endtask

    task automatic restore(input logic ws, input logic cw, input int c, input logic [7:0] d);
        rw_i = 1'b1; ws_i = ws; col_we_i = cw; col_addr_i = 3'(c); col_wdata_i = d;
        tick();
        rw_i = 1'b0; ws_i = 1'b0; col_we_i = 1'b0;
    endtask

    function automatic logic [7:0] rdcol(input int c);
        return 8'h00;
    endfunction

    task automatic readcol(input int c, output logic [7:0] v);
        col_addr_i = 3'(c);
        #1;
        v = col_rdata_o;
    endtask

    task automatic fill(input int r);
        activate(r, 1'b0);
        for (int c = 0; c < 8; c++) colwr(c, pat(r, c));
        restore(1'b0, 1'b0, 0, 8'h00);
    endtask

    task automatic expect_row(input string req, input int r, input int src);
        logic [7:0] v;
        activate(r, 1'b1);
        for (int c = 0; c < 8; c++) begin
            readcol(c, v);
            check(req, v, pat(src, c));
        end
        restore(1'b0, 1'b0, 0, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R8 reset state
        check("R8 open", {7'd0, row_open_o}, 8'h00);
        check("R8 err", {7'd0, copy_err_o}, 8'h00);
        readcol(2, v);
        check("R8 latch", v, 8'h00);

        // R1 R4 table walk: write one column, restore, reopen and read
        for (int i = 0; i < 8; i++) begin
            logic [20:0] e;
            e = VEC[i];
            activate(int'(e[20:11]), 1'b0);
            check("R1 opened", {7'd0, row_open_o}, 8'h01);
            colwr(int'(e[10:8]), e[7:0]);
            readcol(int'(e[10:8]), v);
            check("R3 latch write", v, e[7:0]);
            restore(1'b0, 1'b0, 0, 8'h00);
            check("R4 closed", {7'd0, row_open_o}, 8'h00);
        end
        for (int i = 0; i < 8; i++) begin
            logic [20:0] e;
            e = VEC[i];
            activate(int'(e[20:11]), 1'b0);
            readcol(int'(e[10:8]), v);
            check("R1 R4 readback", v, e[7:0]);
            restore(1'b0, 1'b0, 0, 8'h00);
        end

        // R2 R5 basic copy 5 -> 9
        fill(5); fill(9);
        activate(5, 1'b0);
        restore(1'b0, 1'b0, 0, 8'h00);
        activate(9, 1'b1);
        readcol(4, v);
        check("R1 dest latch", v, pat(9, 4));
        restore(1'b1, 1'b0, 0, 8'h00);
        check("R5 closed", {7'd0, row_open_o}, 8'h00);
        expect_row("R5 copied", 9, 5);
        expect_row("R2 source kept", 5, 5);

        // R4 column write merged into restore
        fill(20);
        activate(20, 1'b0);
        restore(1'b0, 1'b1, 3, 8'hAA);
        activate(20, 1'b1);
        readcol(3, v);
        check("R4 merged write", v, 8'hAA);
        readcol(2, v);
        check("R4 other column", v, pat(20, 2));
        restore(1'b0, 1'b0, 0, 8'h00);

        // R5 column write in copy restore discarded
        fill(21); fill(22);
        activate(21, 1'b0);
        restore(1'b0, 1'b0, 0, 8'h00);
        activate(22, 1'b1);
        restore(1'b1, 1'b1, 2, 8'h55);
        expect_row("R5 write dropped", 22, 21);

        // R3 column write reaches latch only, buffer untouched
        fill(30);
        activate(30, 1'b0);
        colwr(1, 8'h77);
        readcol(1, v);
        check("R3 latch", v, 8'h77);
        restore(1'b1, 1'b0, 0, 8'h00);
        expect_row("R3 array untouched", 30, 30);

        // R6 source equals destination
        fill(40);
        activate(40, 1'b0);
        restore(1'b0, 1'b0, 0, 8'h00);
        activate(40, 1'b1);
        colwr(0, 8'h11);
        restore(1'b1, 1'b0, 0, 8'h00);
        check("R6 err set", {7'd0, copy_err_o}, 8'h01);
        check("R6 closed", {7'd0, row_open_o}, 8'h00);
        tick();
        check("R6 err held", {7'd0, copy_err_o}, 8'h01);
        activate(40, 1'b1);
        check("R6 err cleared", {7'd0, copy_err_o}, 8'h00);
        readcol(0, v);
        check("R6 row unchanged", v, pat(40, 0));
        restore(1'b0, 1'b0, 0, 8'h00);

        // R7 ignored strobes
        fill(50); fill(51);
        activate(50, 1'b0);
        activate(51, 1'b0);
        check("R7 still open", {7'd0, row_open_o}, 8'h01);
        readcol(6, v);
        check("R7 latch kept", v, pat(50, 6));
        restore(1'b0, 1'b0, 0, 8'h00);
        rw_i = 1'b1;
        tick();
        rw_i = 1'b0;
        check("R7 rw idle", {7'd0, row_open_o}, 8'h00);
        readcol(6, v);
        colwr(6, 8'hE7);
        readcol(6, v);
        check("R7 col write idle", v, pat(50, 6));
        // buffer still holds row 50 from the ignored-open sequence
        activate(51, 1'b1);
        restore(1'b1, 1'b0, 0, 8'h00);
        expect_row("R7 R2 buffer from first open", 51, 50);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule